// File: doc/BRIEF.md
# PSK Tag Waveform Synthesizer

This block produces the binary modulation stream a reader-side emulator needs to imitate a phase-shift-keyed low-frequency transponder. A square carrier of programmable length runs without a break from the first data bit onward. Each data bit lasts a programmable number of samples. When a bit differs from the current carrier phase, the first carrier wave of that bit is a phase-change wave, and that wave counts toward the bit's duration.

Data bits arrive through a valid/ready handshake. One 16-bit configuration word sets both the bit length and the carrier length. The output advances by one sample on every enable tick, so the sample rate is set by whoever drives the tick. If no bit is waiting when a bit ends, the block emits a filler bit at the current phase, so the carrier keeps running.

Top module: `psk_tag_synth`

## Requirements
- R1: After reset the block is idle, with `sample_o` = 0 and `bit_ready_o` = 1. It stays idle, with `sample_o` held at 0, through any number of ticks until a bit is offered with `bit_valid_i` = 1.
- R2: `cfg_i[15:8]` is the bit length P in samples and `cfg_i[7:0]` is the carrier length C in samples. Both are captured on the tick that starts a bit (data or filler). A change to `cfg_i` during a bit has no effect on that bit.
- R3: The half wave is h = floor(C/2), and h = 1 when C < 2. Every wave is exactly 2h samples long: h samples at the wave's leading level, then h samples at the inverted level.
- R4: The phase register starts at 0. A data bit equal to the phase leaves it unchanged. A data bit that differs inserts a phase-change wave that leads with the inverted old phase, and the phase toggles after it. As a result, the first sample of every data bit, and of every wave in that bit, equals the bit's value.
- R5: Within a bit, another wave starts only while the samples already used are fewer than P. A bit therefore holds max(1, ceil(P/2h)) waves, and a final wave that overruns P is still emitted in full.
- R6: `bit_ready_o` is 1 while idle and on the final sample of each bit, and 0 at all other times. A bit is taken on a tick with `bit_ready_o` and `bit_valid_i` both 1, and its first sample appears on `sample_o` in the following cycle.
- R7: If `bit_valid_i` is 0 at the end of a bit, a filler bit follows at once. It uses the current phase, causes no phase change, follows the same length rules, and is itself followed by `bit_ready_o` on its final sample.
- R8: Each `tick_i` pulse moves the output forward by exactly one sample. In a cycle without a tick, `sample_o` and `bit_ready_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable; one sample per pulse |
| cfg_i | input | 16 | [15:8] bit length in samples, [7:0] carrier length in samples |
| bit_i | input | 1 | Data bit value |
| bit_valid_i | input | 1 | Data bit offered |
| bit_ready_o | output | 1 | Data bit taken on a tick when high |
| sample_o | output | 1 | Modulation sample |

## Verification
The hardest case to reach is a bit boundary that coincides with a tick gap, a configuration change and a missing data bit, all at the same time. Only then do the filler path, the capture of the configuration word and the hold behaviour interact. Directed runs cover the exact-multiple, overrun, zero-length and odd-carrier cases. A long seeded random run then gates ticks at about 70 %, withholds one bit in eight and rewrites the configuration word at arbitrary moments, so that boundary collisions happen many times. A reference model in the bench, built from bit length and sample index, predicts every sample and every ready level.

// File: rtl/psk_synth_pkg.sv
package psk_synth_pkg;
  localparam int unsigned DEF_PER_W = 8;  // bit length field
  localparam int unsigned DEF_CAR_W = 8;  // carrier length field
endpackage

// File: rtl/psk_wave_gen.sv
module psk_wave_gen #(
  parameter int unsigned CAR_W = psk_synth_pkg::DEF_CAR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             step_i,
  input  logic             active_i,
  input  logic             phase_i,
  input  logic [CAR_W-1:0] car_i,
  output logic             wave_last_o,
  output logic             sample_o
);
  localparam int unsigned HALF_W = CAR_W - 1;

  logic [HALF_W-1:0] half_raw, half;
  logic [CAR_W-1:0]  wlen_m1;
  logic [CAR_W-1:0]  wpos_q;

  assign half_raw = car_i[CAR_W-1:1];
  assign half     = (half_raw == '0) ? HALF_W'(1) : half_raw;
  assign wlen_m1  = {half, 1'b0} - CAR_W'(1);

  assign wave_last_o = (wpos_q == wlen_m1);
  // leading half carries the phase, trailing half its inverse
  assign sample_o = active_i & ((wpos_q < {1'b0, half}) ? phase_i : ~phase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wpos_q <= '0;
    else if (launch_i) wpos_q <= '0;
    else if (step_i)   wpos_q <= wave_last_o ? '0 : wpos_q + CAR_W'(1);
  end
endmodule

// File: rtl/psk_bit_budget.sv
module psk_bit_budget #(
  parameter int unsigned PER_W = psk_synth_pkg::DEF_PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             step_i,
  input  logic             wave_last_i,
  input  logic [PER_W-1:0] per_i,
  output logic             bit_last_o
);
  // headroom for the overrunning final wave
  localparam int unsigned CNT_W = PER_W + 1;

  logic [CNT_W-1:0] used_q, used_nx;

  assign used_nx    = used_q + CNT_W'(1);
  assign bit_last_o = wave_last_i && (used_nx >= CNT_W'(per_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       used_q <= '0;
    else if (launch_i) used_q <= '0;
    else if (step_i)   used_q <= used_nx;
  end
endmodule

// File: rtl/psk_phase_seq.sv
module psk_phase_seq #(
  parameter int unsigned PER_W = psk_synth_pkg::DEF_PER_W,
  parameter int unsigned CAR_W = psk_synth_pkg::DEF_CAR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   bit_i,
  input  logic                   bit_valid_i,
  input  logic [PER_W+CAR_W-1:0] cfg_i,
  input  logic                   bit_last_i,
  output logic                   ready_o,
  output logic                   launch_o,
  output logic                   step_o,
  output logic                   active_o,
  output logic                   phase_o,
  output logic [PER_W-1:0]       per_o,
  output logic [CAR_W-1:0]       car_o
);
  logic active_q, phase_q, take;
  logic [PER_W-1:0] per_q;
  logic [CAR_W-1:0] car_q;

  assign ready_o  = !active_q || bit_last_i;
  assign take     = tick_i && ready_o && bit_valid_i;
  // a running stream never stalls: no data means a filler bit
  assign launch_o = tick_i && ready_o && (bit_valid_i || active_q);
  assign step_o   = tick_i && active_q && !bit_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      per_q    <= '0;
      car_q    <= '0;
    end else begin
      if (take) phase_q <= bit_i;  // differing bit == phase flip
      if (launch_o) begin
        active_q <= 1'b1;
        per_q    <= cfg_i[PER_W+CAR_W-1:CAR_W];
        car_q    <= cfg_i[CAR_W-1:0];
      end
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign per_o    = per_q;
  assign car_o    = car_q;
endmodule

// File: rtl/psk_tag_synth.sv
module psk_tag_synth #(
  parameter int unsigned PER_W = psk_synth_pkg::DEF_PER_W,
  parameter int unsigned CAR_W = psk_synth_pkg::DEF_CAR_W,
  localparam int unsigned CFG_W = PER_W + CAR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  output logic             bit_ready_o,
  output logic             sample_o
);
  logic launch, step, active, phase, wave_last, bit_last;
  logic [PER_W-1:0] per_lat;
  logic [CAR_W-1:0] car_lat;

  psk_phase_seq #(.PER_W(PER_W), .CAR_W(CAR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .bit_i      (bit_i),
    .bit_valid_i(bit_valid_i),
    .cfg_i      (cfg_i),
    .bit_last_i (bit_last),
    .ready_o    (bit_ready_o),
    .launch_o   (launch),
    .step_o     (step),
    .active_o   (active),
    .phase_o    (phase),
    .per_o      (per_lat),
    .car_o      (car_lat)
  );

  psk_wave_gen #(.CAR_W(CAR_W)) u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .step_i     (step),
    .active_i   (active),
    .phase_i    (phase),
    .car_i      (car_lat),
    .wave_last_o(wave_last),
    .sample_o   (sample_o)
  );

  psk_bit_budget #(.PER_W(PER_W)) u_budget (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .step_i     (step),
    .wave_last_i(wave_last),
    .per_i      (per_lat),
    .bit_last_o (bit_last)
  );
endmodule

// File: rtl/psk_tag_synth_chk.sv
module psk_tag_synth_chk #(
  parameter int unsigned PER_W = psk_synth_pkg::DEF_PER_W,
  parameter int unsigned CAR_W = psk_synth_pkg::DEF_CAR_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic [PER_W+CAR_W-1:0] cfg_i,
  input logic                   bit_i,
  input logic                   bit_valid_i,
  input logic                   bit_ready_o,
  input logic                   sample_o,
  input logic                   active,
  input logic                   phase,
  input logic [PER_W-1:0]       per_lat,
  input logic [CAR_W-1:0]       car_lat
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (bit_ready_o && !sample_o));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && bit_ready_o) |=> ($stable(per_lat) && $stable(car_lat)));

  p_cfg_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && bit_ready_o && (bit_valid_i || active)) |=>
      (per_lat == $past(cfg_i[PER_W+CAR_W-1:CAR_W]) && car_lat == $past(cfg_i[CAR_W-1:0])));

  p_first_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && bit_ready_o && bit_valid_i) |=> (sample_o == $past(bit_i)));

  p_phase_mid_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !bit_ready_o) |=> $stable(phase));

  p_filler_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && bit_ready_o && !bit_valid_i) |=> $stable(phase));

  p_hold_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(sample_o) && $stable(bit_ready_o)));
endmodule

bind psk_tag_synth psk_tag_synth_chk #(.PER_W(PER_W), .CAR_W(CAR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cfg_i      (cfg_i),
  .bit_i      (bit_i),
  .bit_valid_i(bit_valid_i),
  .bit_ready_o(bit_ready_o),
  .sample_o   (sample_o),
  .active     (active),
  .phase      (phase),
  .per_lat    (per_lat),
  .car_lat    (car_lat)
);

// File: tb/psk_tag_synth_test.sv
`timescale 1ns/1ps
module psk_tag_synth_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [15:0] cfg_i = 16'h0;
  logic bit_i = 1'b0;
  logic bit_valid_i = 1'b0;
  logic bit_ready_o, sample_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // reference model state (predicts outputs after the next edge)
  int m_active = 0, m_phase = 0, m_filler = 0, m_k = 0, m_len = 0, m_h = 1, m_took = 0;
  logic [15:0] m_cfg = 16'h0;
  int prev_tick = 0;

  always #2 clk = ~clk;  // 250 MHz

  psk_tag_synth uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cfg_i      (cfg_i),
    .bit_i      (bit_i),
    .bit_valid_i(bit_valid_i),
    .bit_ready_o(bit_ready_o),
    .sample_o   (sample_o)
  );

  function automatic int half_f(int car);
    int h = car / 2;
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int len_f(int per, int car);
    int wl = 2 * half_f(car);
    int nw = (per + wl - 1) / wl;
    if (nw < 1) nw = 1;
    return nw * wl;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int last = (m_active != 0) && (m_k == m_len - 1);
    int exp_s = (m_active == 0) ? 0 :
                (((m_k % (2 * m_h)) < m_h) ? m_phase : 1 - m_phase);
    int exp_r = ((m_active == 0) || last) ? 1 : 0;
    string stag;
    if (m_active == 0)         stag = "R1";
    else if (prev_tick == 0)   stag = "R8";
    else if (cfg_i != m_cfg)   stag = "R2";
    else if (m_k == 0 && m_filler != 0) stag = "R7";
    else if (m_k == 0)         stag = "R4";
    else                       stag = "R3";
    check(stag, int'(sample_o), exp_s);
    check((m_active != 0 && exp_r == 1) ? "R5" : "R6", int'(bit_ready_o), exp_r);
  endtask

  task automatic model_update(input int t, input int v, input int b, input logic [15:0] c);
    int last = (m_active != 0) && (m_k == m_len - 1);
    m_took = 0;
    if (t == 0) return;
    if (m_active == 0 || last) begin
      if (v != 0 || m_active != 0) begin
        m_active = 1;
        if (v != 0) begin m_phase = b; m_filler = 0; m_took = 1; end
        else m_filler = 1;
        m_cfg = c;
        m_h   = half_f(int'(c[7:0]));
        m_len = len_f(int'(c[15:8]), int'(c[7:0]));
        m_k   = 0;
      end
    end else begin
      m_k++;
    end
  endtask

  // one cycle: check at negedge, drive, predict, wait
  task automatic step(input int t, input int v, input int b, input logic [15:0] c);
    check_outputs();
    tick_i = t[0];
    bit_valid_i = v[0];
    bit_i = b[0];
    cfg_i = c;
    model_update(t, v, b, c);
    prev_tick = t;
    @(negedge clk);
  endtask

  task automatic drive_bits(input logic [15:0] c, input logic [31:0] pat, input int nbits);
    int idx = 0;
    while (idx < nbits) begin
      step(1, 1, int'(pat[idx]), c);
      if (m_took != 0) idx++;
    end
  endtask

  task automatic run_out(input logic [15:0] c, input int cycles);
    for (int i = 0; i < cycles; i++) step(1, 0, 0, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got 1 expected 0 (run did not end)");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(sample_o), 0);
    check("R1", int'(bit_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 ticks without data keep it idle
    for (int i = 0; i < 6; i++) step(1, 0, 0, 16'h2008);
    // R8 no tick while offering data: nothing taken
    for (int i = 0; i < 4; i++) step(0, 1, 1, 16'h2008);
    // R4 R5 exact multiple: C=8, P=32
    drive_bits(16'h2008, 32'b1_0_0_1_1, 5);
    // R5 overrun: C=10, P=25 -> 3 waves, 30 samples
    drive_bits(16'h190A, 32'b0_1_1, 3);
    // R3 odd carrier C=9 -> h=4, P=25 -> 32 samples
    drive_bits(16'h1909, 32'b1_0, 2);
    // R3 R5 carrier 1 -> h=1, P=0 -> single wave
    drive_bits(16'h0001, 32'b0_1_0_1, 4);
    // R5 P=0 with C=8 -> one wave
    drive_bits(16'h0008, 32'b1_1_0, 3);
    // R7 filler bits then resume
    run_out(16'h1006, 40);
    drive_bits(16'h1006, 32'b0_1, 2);
    // R2 cfg change mid bit
    drive_bits(16'h3008, 32'b1, 1);
    for (int i = 0; i < 70; i++) step(1, 1, 0, (i < 20) ? 16'h0A04 : 16'h3008);
    // random mix
    begin
      logic [15:0] c = 16'h2008;
      for (int n = 0; n < 20000; n++) begin
        int t = (($urandom % 10) < 7) ? 1 : 0;
        int v = (($urandom % 8) != 0) ? 1 : 0;
        int b = int'($urandom % 2);
        if (($urandom % 20) == 0) begin
          c[7:0]  = 8'($urandom % 21);
          c[15:8] = 8'($urandom % 70);
        end
        step(t, v, b, c);
      end
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule